// File: doc/BRIEF.md
# Interrupt-capable general-purpose pin controller

This block gives software a bank of up to 32 general-purpose pins behind a plain 32-bit register bus made of an address, a write strobe, write data and read data. Each pin can be an output, driven from a stored level, or an input. The level at each pad is always visible through a two-flop synchronizer, whatever the pin's direction.

Every pin also has its own interrupt detector. The detector can fire on a high level, a low level, a rising edge, a falling edge or both edges. Detected events collect in a raw status register. A per-pin enable masks them into a pending view. The OR of all pending bits drives a single interrupt line. Software acknowledges an event by writing ones to a clear register. A read-only version word reports that the both-edges mode exists.

Register offsets are byte addresses of 32-bit words. Bit i of every register belongs to pin i.

Top module: `pinbank_ctrl`

## Requirements
- R1: The direction register (offset 0x04) holds one bit per pin. A 1 makes the pin an input (`pin_oe` low), and a 0 makes it an output (`pin_oe` high). After a write, `pin_oe` follows on the next cycle.
- R2: A write to offset 0x00 sets `pin_out`. A read of offset 0x00 returns the synchronized pad levels of `pin_in`. A pad change is visible in that read two rising edges after it is applied.
- R3: When a pin's mode bit (offset 0x18) is 0, its trigger is a level. A polarity bit (offset 0x1C) of 1 means active-high, and 0 means active-low. While the level stays active, the status bit is set again on every cycle, including the cycle of a clear.
- R4: When a pin's mode bit is 1 and its both-edges bit is 0, its trigger is an edge. A polarity bit of 1 means rising and 0 means falling. An edge event stays latched in status until it is cleared. It shows in status on the third rising edge after the pad changes.
- R5: When a pin's both-edges bit (offset 0x24) is 1 and its mode bit is 1, either transition latches an event. When the mode bit is 0, the both-edges bit has no effect and the pin behaves as a level trigger.
- R6: Offset 0x0C reads the raw status. Offset 0x10 reads status AND the enable register (offset 0x08). `irq` is high exactly when some pending bit is 1.
- R7: Writing offset 0x14 clears each status bit whose data bit is 1. Data bits of 0 leave status unchanged. Offset 0x14 reads as zero.
- R8: The enable register resets to zero, so `irq` is low after reset.
- R9: Offset 0x20 reads 3, which indicates that the both-edges mode is present. Writes to it are ignored.
- R10: Register bits at positions at or above the pin count read as zero, and writes to them are ignored.
- R11: After reset, the output value, mode and both-edges registers are all zero, direction and polarity are all ones, and status is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | NPINS | Pad levels |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench sweeps an 8-pin build. Every pin is tried in six trigger settings: level high, level low, rising, falling, both edges, and both-edges with edge mode off. Each pin sees a low-high-low pad sequence, and status is read after each transition and after each acknowledge.

The rising pattern tells edge polarity and the both-edges mode apart. Reading status again after a clear separates latched edge events from level sources that re-assert. A partial clear with the pin's own bit at zero shows that zero bits leave status alone.

Directed checks cover the reset values, output and direction control, pad readback timing, masking of bits above the pin count, and the read-only version word.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int unsigned BUS_W = 32;

    // Byte offsets of the register words; software depends on these.
    localparam int unsigned OFS_LEVEL  = 'h00;
    localparam int unsigned OFS_DIR    = 'h04;
    localparam int unsigned OFS_ENABLE = 'h08;
    localparam int unsigned OFS_STATUS = 'h0C;
    localparam int unsigned OFS_PEND   = 'h10;
    localparam int unsigned OFS_ACK    = 'h14;
    localparam int unsigned OFS_MODE   = 'h18;
    localparam int unsigned OFS_POL    = 'h1C;
    localparam int unsigned OFS_VER    = 'h20;
    localparam int unsigned OFS_ANY    = 'h24;

    // Per-pin trigger configuration.
    typedef struct packed {
        logic edge_mode;   // 0: level, 1: edge
        logic polarity;    // level: 1 high / 0 low; edge: 1 rise / 0 fall
        logic any_edge;    // with edge_mode, fire on either transition
    } trig_cfg_t;

    function automatic logic trig_fire(trig_cfg_t c, logic cur, logic prev);
        logic fire;
        if (!c.edge_mode)
            fire = c.polarity ? cur : ~cur;
        else if (c.any_edge)
            fire = cur ^ prev;
        else if (c.polarity)
            fire = cur & ~prev;
        else
            fire = ~cur & prev;
        return fire;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur  = cur_q;
    assign prev = prev_q;
endmodule

// File: rtl/pinbank_trig.sv
module pinbank_trig
    import pinbank_pkg::*;
(
    input  trig_cfg_t cfg,
    input  logic      cur,
    input  logic      prev,
    output logic      fire
);
    always_comb fire = trig_fire(cfg, cur, prev);
endmodule

// File: rtl/pinbank_evt.sv
module pinbank_evt #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] fire,
    input  logic         ack_we,
    input  logic [W-1:0] ack_mask,
    input  logic [W-1:0] enable,
    output logic [W-1:0] status,
    output logic [W-1:0] pending,
    output logic         irq
);
    logic [W-1:0] status_q;
    logic [W-1:0] ack_bits;

    assign ack_bits = ack_we ? ack_mask : '0;

    // A firing source wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~ack_bits) | fire;
    end

    assign status  = status_q;
    assign pending = status_q & enable;
    assign irq     = |pending;

    // R4: every firing source is latched on the next edge
    p_fire_latched_r4: assert property (@(posedge clk) disable iff (rst)
        (fire != '0) |=> ((status & $past(fire)) == $past(fire)));

    // R7: an acknowledged bit with no new event is cleared
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        ((ack_bits & ~fire) != '0) |=> ((status & $past(ack_bits & ~fire)) == '0));

    // R7: bits not acknowledged keep their value
    p_hold_unacked_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(status & ~ack_bits)) == $past(status & ~ack_bits)));
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS   = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned VERSION = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_LEVEL  = ADDR_W'(OFS_LEVEL);
    localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFS_ACK);
    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_POL    = ADDR_W'(OFS_POL);
    localparam logic [ADDR_W-1:0] A_VER    = ADDR_W'(OFS_VER);
    localparam logic [ADDR_W-1:0] A_ANY    = ADDR_W'(OFS_ANY);

    logic [NPINS-1:0] level_q, dir_q, enable_q, mode_q, pol_q, any_q;
    logic [NPINS-1:0] wbits;
    logic [NPINS-1:0] sync_cur, sync_prev, fire;
    logic [NPINS-1:0] status, pending;
    logic             ack_we;

    assign wbits  = bus_wdata[NPINS-1:0];
    assign ack_we = bus_we && (bus_addr == A_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q  <= '0;
            dir_q    <= '1;
            enable_q <= '0;
            mode_q   <= '0;
            pol_q    <= '1;
            any_q    <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_LEVEL)  level_q  <= wbits;
            if (bus_addr == A_DIR)    dir_q    <= wbits;
            if (bus_addr == A_ENABLE) enable_q <= wbits;
            if (bus_addr == A_MODE)   mode_q   <= wbits;
            if (bus_addr == A_POL)    pol_q    <= wbits;
            if (bus_addr == A_ANY)    any_q    <= wbits;
        end
    end

    pinbank_sync #(.W(NPINS)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pad  (pin_in),
        .cur  (sync_cur),
        .prev (sync_prev)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        trig_cfg_t cfg;
        assign cfg = '{edge_mode: mode_q[i], polarity: pol_q[i], any_edge: any_q[i]};
        pinbank_trig u_trig (
            .cfg  (cfg),
            .cur  (sync_cur[i]),
            .prev (sync_prev[i]),
            .fire (fire[i])
        );
    end

    pinbank_evt #(.W(NPINS)) u_evt (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .ack_we   (ack_we),
        .ack_mask (wbits),
        .enable   (enable_q),
        .status   (status),
        .pending  (pending),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_LEVEL:  bus_rdata = BUS_W'(sync_cur);
            A_DIR:    bus_rdata = BUS_W'(dir_q);
            A_ENABLE: bus_rdata = BUS_W'(enable_q);
            A_STATUS: bus_rdata = BUS_W'(status);
            A_PEND:   bus_rdata = BUS_W'(pending);
            A_MODE:   bus_rdata = BUS_W'(mode_q);
            A_POL:    bus_rdata = BUS_W'(pol_q);
            A_VER:    bus_rdata = BUS_W'(VERSION);
            A_ANY:    bus_rdata = BUS_W'(any_q);
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_out = level_q;
    assign pin_oe  = ~dir_q;

    // R1: a direction write shows on pin_oe one cycle later
    p_dir_to_oe_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_DIR) |=> (pin_oe == ~$past(wbits)));

    // R8: interrupt line is low on the first cycle after reset
    p_irq_quiet_r8: assert property (@(posedge clk)
        $fell(rst) |-> !irq);
endmodule

// File: tb/pinbank_ctrl_bench.sv
module pinbank_ctrl_bench;
    localparam int N = 8;
    localparam logic [7:0] O_LVL = 8'h00, O_DIR = 8'h04, O_EN = 8'h08, O_ST = 8'h0C,
                           O_PD = 8'h10, O_ACK = 8'h14, O_MODE = 8'h18, O_POL = 8'h1C,
                           O_VER = 8'h20, O_ANY = 8'h24;

    logic        clk = 0;
    logic        rst = 1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe;
    logic        irq;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pinbank_ctrl #(.NPINS(N), .ADDR_W(8), .VERSION(3)) u_pinbank_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        tick(3);
        rst = 0;
        tick(1);
        // R11 / R8 reset state
        rd(O_DIR, v);  check("R11 dir reset", v, 32'hFF);
        rd(O_POL, v);  check("R11 pol reset", v, 32'hFF);
        rd(O_MODE, v); check("R11 mode reset", v, 32'h0);
        rd(O_ANY, v);  check("R11 both reset", v, 32'h0);
        rd(O_ST, v);   check("R11 status reset", v, 32'h0);
        rd(O_EN, v);   check("R8 enable reset", v, 32'h0);
        check("R8 irq after reset", {31'b0, irq}, 32'h0);
        check("R11 pin_out reset", {24'b0, pin_out}, 32'h0);
        check("R1 pin_oe reset", {24'b0, pin_oe}, 32'h0);
        // R9 version
        rd(O_VER, v);  check("R9 version", v, 32'd3);
        wr(O_VER, 32'h0);
        rd(O_VER, v);  check("R9 version write ignored", v, 32'd3);
        // R2 output and readback
        wr(O_LVL, 32'hFFFF_FFA5);
        check("R2 pin_out", {24'b0, pin_out}, 32'hA5);
        pin_in = 8'h3C;
        tick(1);
        rd(O_LVL, v);  check("R2 readback not yet", v, 32'h0);
        tick(1);
        rd(O_LVL, v);  check("R2 readback two edges", v, 32'h3C);
        pin_in = 8'h00;
        tick(2);
        rd(O_LVL, v);  check("R2 readback low", v, 32'h0);
        // R10 / R1
        wr(O_DIR, 32'hFFFF_FFFF);
        rd(O_DIR, v);  check("R10 upper bits zero", v, 32'hFF);
        check("R1 all inputs", {24'b0, pin_oe}, 32'h0);
        wr(O_DIR, 32'h0F);
        check("R1 outputs enabled", {24'b0, pin_oe}, 32'hF0);
        wr(O_DIR, 32'hFF);
        rd(O_ACK, v);  check("R7 ack reads zero", v, 32'h0);

        for (int p = 0; p < N; p++) begin
            for (int m = 0; m < 6; m++) begin
                logic [7:0] bit_p;
                logic edg, pl, anyb, eA, eB1, eB2, eC1, eC2;
                bit_p = 8'(1 << p);
                // modes: 0 lvl-high, 1 lvl-low, 2 rise, 3 fall, 4 both, 5 both bit w/o edge
                edg  = (m == 2 || m == 3 || m == 4);
                pl   = !(m == 1 || m == 3);
                anyb = (m == 4 || m == 5);
                eA  = (m == 1);
                eB1 = (m != 3);
                eB2 = (m == 0 || m == 5);
                eC1 = (m != 2);
                eC2 = (m == 1);
                wr(O_MODE, {24'b0, edg ? bit_p : 8'h00});
                wr(O_POL,  {24'b0, pl ? 8'hFF : ~bit_p});
                wr(O_ANY,  {24'b0, anyb ? bit_p : 8'h00});
                wr(O_EN,   {24'b0, bit_p});
                tick(4);
                wr(O_ACK, 32'hFF);
                rd(O_ST, v);
                check($sformatf("R3 low pad p%0d m%0d", p, m), v, {24'b0, eA ? bit_p : 8'h00});
                pin_in[p] = 1'b1;
                tick(4);
                rd(O_ST, v);
                check($sformatf("R4 R5 rise p%0d m%0d", p, m), v, {24'b0, eB1 ? bit_p : 8'h00});
                rd(O_PD, v);
                check($sformatf("R6 pending p%0d m%0d", p, m), v, {24'b0, eB1 ? bit_p : 8'h00});
                check($sformatf("R6 irq p%0d m%0d", p, m), {31'b0, irq}, {31'b0, eB1});
                wr(O_ACK, {24'b0, ~bit_p});
                rd(O_ST, v);
                check($sformatf("R7 zero bits p%0d m%0d", p, m), v, {24'b0, eB1 ? bit_p : 8'h00});
                wr(O_ACK, {24'b0, bit_p});
                rd(O_ST, v);
                check($sformatf("R3 R7 after clear high p%0d m%0d", p, m), v, {24'b0, eB2 ? bit_p : 8'h00});
                pin_in[p] = 1'b0;
                tick(4);
                rd(O_ST, v);
                check($sformatf("R4 R5 fall p%0d m%0d", p, m), v, {24'b0, eC1 ? bit_p : 8'h00});
                wr(O_ACK, {24'b0, bit_p});
                rd(O_ST, v);
                check($sformatf("R3 after clear low p%0d m%0d", p, m), v, {24'b0, eC2 ? bit_p : 8'h00});
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule